// File: doc/BRIEF.md
# Colour-Masked Activation Frame Store

This block holds a set of activation frames for a static dataflow processing element. Each frame is one 144-bit instruction record: a readiness flag (INIT), an operation code, eight operand-state flags, a 32-bit subgraph colour, two 32-bit operands and a 32-bit destination address. While the block is held in load mode, software-side mapping logic writes frames one at a time through an indexed load port. A frame can be written with its INIT flag either set or clear.

Outside load mode the block accepts group commands that arm or disarm instructions by subgraph colour. A command carries a colour operand and a prefix length from 1 to 32. Every frame whose colour agrees with the operand over that many leading (most significant) bits is updated in the same clock edge. Whole-graph variants touch every frame and do no compare. The INIT flags of all frames are exposed as a vector for the firing logic. Any single frame can be read combinationally by index.

Top module: `afs_colour_store`

## Requirements
- R1: After synchronous reset every frame reads as all zeros, `ready_vec` is all zeros and `cmd_err` is low.
- R2: With `load_mode` high and `ld_we` high, the frame at `ld_addr` takes `ld_frame` at the clock edge. Its INIT flag (bit 143) is set or clear exactly as supplied. The new contents show on `rd_frame` and `ready_vec` right after that edge.
- R3: A load write with `load_mode` low changes no frame.
- R4: A command presented while `load_mode` is high changes no frame and raises no error.
- R5: Command code 1 (arm all) sets INIT in every frame and leaves all other fields unchanged.
- R6: Command code 2 (disarm all) clears INIT in every frame and leaves all other fields unchanged.
- R7: Command code 3 (arm subgraph) with length L in 1..32 sets INIT in every frame whose colour field (bits 127:96) equals `cmd_color` in its top L bits. All other frames are unchanged. With L=30, operand 4 matches colours 4, 5, 6 and 7.
- R8: Command code 5 (disarm subgraph) clears INIT under the same prefix-match rule as R7.
- R9: Command code 4 (arm subgraph with operand reset) matches as in R7 and sets INIT. It clears operand-A ready (bit 134) unless operand-A immediate (bit 131) is set, and clears operand-B ready (bit 132) unless operand-B immediate (bit 130) is set.
- R10: A subgraph command (codes 3, 4, 5) with length 0 or above 32 changes no frame. `cmd_err` is high for exactly the cycle after it and low otherwise.
- R11: The length bounds are exact. L=32 matches only an identical colour, and L=1 compares only bit 31.
- R12: Command codes 0, 6 and 7 change no frame and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_mode | input | 1 | High: indexed loading allowed, commands ignored |
| ld_we | input | 1 | Load write strobe |
| ld_addr | input | ADDR_W | Frame index for load |
| ld_frame | input | 144 | Frame contents to load |
| cmd_valid | input | 1 | Group command strobe |
| cmd_op | input | 3 | Command code (see R5 to R12) |
| cmd_color | input | 32 | Colour operand |
| cmd_len | input | 7 | Prefix length operand |
| rd_addr | input | ADDR_W | Frame index for read |
| rd_frame | output | 144 | Contents of frame `rd_addr` (combinational) |
| ready_vec | output | DEPTH | INIT flag of every frame |
| cmd_err | output | 1 | Bad-length flag, one cycle after the command |

## Verification
Loads and commands take effect at the first rising edge that samples them. `ready_vec` and `rd_frame` therefore show the result one time step after that edge. `cmd_err` is registered on the same edge and falls again on the following edge. The bench drives inputs and samples outputs one time unit after each rising edge. It compares every frame against a bench-side model after each scenario and checks `cmd_err` both one and two edges after a command.

// File: rtl/afs_pkg.sv
package afs_pkg;
    localparam int FRAME_W = 144;
    localparam int TAG_W   = 32;
    localparam int LEN_W   = 7;
    localparam int OPC_W   = 3;

    typedef struct packed {
        logic             init;
        logic [6:0]       opcode;
        logic             need_a;
        logic             rdy_a;
        logic             need_b;
        logic             rdy_b;
        logic             imm_a;
        logic             imm_b;
        logic             tgt_b;
        logic             spare;
        logic [TAG_W-1:0] color;
        logic [31:0]      opnd_a;
        logic [31:0]      opnd_b;
        logic [31:0]      dest;
    } frame_t;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP          = 3'd0,
        OP_INIT_ALL     = 3'd1,
        OP_KILL_ALL     = 3'd2,
        OP_INIT_SUB     = 3'd3,
        OP_INIT_SUB_OPS = 3'd4,
        OP_KILL_SUB     = 3'd5,
        OP_RSV6         = 3'd6,
        OP_RSV7         = 3'd7
    } cmd_op_e;

    typedef struct packed {
        logic set_init;
        logic clr_init;
        logic clr_rdy;
        logic use_mask;
        logic bad_len;
    } action_t;

    function automatic logic [TAG_W-1:0] prefix_mask(input logic [LEN_W-1:0] len);
        logic [TAG_W-1:0] m;
        for (int i = 0; i < TAG_W; i++) begin
            m[TAG_W-1-i] = (i < int'(len));
        end
        return m;
    endfunction

    function automatic logic len_legal(input logic [LEN_W-1:0] len);
        return (len >= LEN_W'(1)) && (len <= LEN_W'(TAG_W));
    endfunction
endpackage

// File: rtl/afs_cmd_decode.sv
module afs_cmd_decode
    import afs_pkg::*;
(
    input  logic             cmd_valid,
    input  logic             load_mode,
    input  logic [OPC_W-1:0] cmd_op,
    input  logic [LEN_W-1:0] cmd_len,
    output action_t          act
);
    logic accept;
    assign accept = cmd_valid && !load_mode;

    always_comb begin
        act = '0;
        if (accept) begin
            case (cmd_op_e'(cmd_op))
                OP_INIT_ALL: act.set_init = 1'b1;
                OP_KILL_ALL: act.clr_init = 1'b1;
                OP_INIT_SUB, OP_INIT_SUB_OPS, OP_KILL_SUB: begin
                    if (!len_legal(cmd_len)) begin
                        act.bad_len = 1'b1;
                    end else begin
                        act.use_mask = 1'b1;
                        act.set_init = (cmd_op != OP_KILL_SUB);
                        act.clr_init = (cmd_op == OP_KILL_SUB);
                        act.clr_rdy  = (cmd_op == OP_INIT_SUB_OPS);
                    end
                end
                default: act = '0;
            endcase
        end
    end
endmodule

// File: rtl/afs_color_match.sv
module afs_color_match
    import afs_pkg::*;
(
    input  logic [TAG_W-1:0] frame_tag,
    input  logic [TAG_W-1:0] cmd_tag,
    input  logic [TAG_W-1:0] cmp_mask,
    input  logic             use_mask,
    output logic             hit
);
    logic [TAG_W-1:0] diff;
    assign diff = (frame_tag ^ cmd_tag) & cmp_mask;
    assign hit  = !use_mask || (diff == '0);
endmodule

// File: rtl/afs_frame_slot.sv
module afs_frame_slot
    import afs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    we,
    input  frame_t  wdata,
    input  logic    hit,
    input  action_t act,
    output frame_t  frame_q
);
    logic touch;
    assign touch = hit && (act.set_init || act.clr_init);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
        end else if (we) begin
            frame_q <= wdata;
        end else if (touch) begin
            if (act.set_init) frame_q.init <= 1'b1;
            if (act.clr_init) frame_q.init <= 1'b0;
            if (act.clr_rdy) begin
                if (!frame_q.imm_a) frame_q.rdy_a <= 1'b0;
                if (!frame_q.imm_b) frame_q.rdy_b <= 1'b0;
            end
        end
    end

    // R2
    load_takes_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (frame_q == $past(wdata)));

    // R7
    untouched_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!we && !hit) |=> $stable(frame_q));

    // R9
    imm_ready_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (!we && frame_q.imm_a && frame_q.rdy_a) |=> frame_q.rdy_a);
endmodule

// File: rtl/afs_colour_store.sv
module afs_colour_store
    import afs_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_mode,
    input  logic               ld_we,
    input  logic [ADDR_W-1:0]  ld_addr,
    input  logic [FRAME_W-1:0] ld_frame,
    input  logic               cmd_valid,
    input  logic [OPC_W-1:0]   cmd_op,
    input  logic [TAG_W-1:0]   cmd_color,
    input  logic [LEN_W-1:0]   cmd_len,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [FRAME_W-1:0] rd_frame,
    output logic [DEPTH-1:0]   ready_vec,
    output logic               cmd_err
);
    localparam logic [ADDR_W:0] DEPTH_L = (ADDR_W+1)'(DEPTH);

    action_t          act;
    logic [TAG_W-1:0] mask;
    logic             load_acc;
    frame_t           wframe;
    frame_t           frames [DEPTH];

    assign load_acc = load_mode && ld_we && ({1'b0, ld_addr} < DEPTH_L);
    assign wframe   = frame_t'(ld_frame);
    assign mask     = prefix_mask(cmd_len);

    afs_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .load_mode (load_mode),
        .cmd_op    (cmd_op),
        .cmd_len   (cmd_len),
        .act       (act)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
        logic hit;

        afs_color_match u_match (
            .frame_tag (frames[i].color),
            .cmd_tag   (cmd_color),
            .cmp_mask  (mask),
            .use_mask  (act.use_mask),
            .hit       (hit)
        );

        afs_frame_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .we      (load_acc && (ld_addr == IDX)),
            .wdata   (wframe),
            .hit     (hit),
            .act     (act),
            .frame_q (frames[i])
        );

        assign ready_vec[i] = frames[i].init;
    end

    assign rd_frame = ({1'b0, rd_addr} < DEPTH_L) ? frames[rd_addr] : '0;

    always_ff @(posedge clk) begin
        if (rst) cmd_err <= 1'b0;
        else     cmd_err <= act.bad_len;
    end

    // R5
    init_all_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !load_mode && cmd_op == OP_INIT_ALL) |=> (&ready_vec));

    // R6
    kill_all_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !load_mode && cmd_op == OP_KILL_ALL) |=> (ready_vec == '0));

    // R4
    load_mode_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (load_mode && !ld_we) |=> ($stable(ready_vec) && !cmd_err));

    // R10
    bad_len_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !load_mode && (cmd_op inside {3'd3, 3'd4, 3'd5})
         && (cmd_len == 7'd0 || cmd_len > 7'd32)) |=> (cmd_err && $stable(ready_vec)));

    // R12
    reserved_op_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_mode && (!cmd_valid || cmd_op inside {3'd0, 3'd6, 3'd7}))
        |=> ($stable(ready_vec) && !cmd_err));
endmodule

// File: tb/afs_colour_store_test.sv
module afs_colour_store_test;
    import afs_pkg::*;

    localparam int DEPTH = 8;
    localparam int AW    = 3;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               load_mode = 1'b0;
    logic               ld_we = 1'b0;
    logic [AW-1:0]      ld_addr = '0;
    logic [FRAME_W-1:0] ld_frame = '0;
    logic               cmd_valid = 1'b0;
    logic [OPC_W-1:0]   cmd_op = '0;
    logic [TAG_W-1:0]   cmd_color = '0;
    logic [LEN_W-1:0]   cmd_len = '0;
    logic [AW-1:0]      rd_addr = '0;
    logic [FRAME_W-1:0] rd_frame;
    logic [DEPTH-1:0]   ready_vec;
    logic               cmd_err;

    int runs  = 0;
    int fails = 0;
    frame_t model [DEPTH];

    always #5 clk = ~clk;

    afs_colour_store #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .load_mode(load_mode), .ld_we(ld_we),
        .ld_addr(ld_addr), .ld_frame(ld_frame), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_color(cmd_color), .cmd_len(cmd_len),
        .rd_addr(rd_addr), .rd_frame(rd_frame), .ready_vec(ready_vec),
        .cmd_err(cmd_err)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [FRAME_W-1:0] act, input logic [FRAME_W-1:0] exp);
        runs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic frame_t mk(input logic [31:0] col, input bit ini,
                                  input bit ia, input bit ib, input int idx);
        frame_t f;
        f = '0;
        f.init = ini; f.opcode = 7'(idx + 3);
        f.need_a = 1'b1; f.rdy_a = 1'b1; f.need_b = 1'b1; f.rdy_b = 1'b1;
        f.imm_a = ia; f.imm_b = ib; f.tgt_b = idx[0];
        f.color = col;
        f.opnd_a = 32'h1111_0000 + 32'(idx);
        f.opnd_b = 32'h2222_0000 + 32'(idx);
        f.dest   = 32'h3333_0000 + 32'(idx);
        return f;
    endfunction

    function automatic bit prefix_eq(input logic [31:0] a, input logic [31:0] b, input int len);
        for (int k = 0; k < len; k++) if (a[31-k] != b[31-k]) return 1'b0;
        return 1'b1;
    endfunction

    // bench-side model of one accepted command (outside load mode)
    task automatic model_cmd(input int op, input logic [31:0] col, input int len,
                             output bit err);
        err = 1'b0;
        if (op == 1) for (int i = 0; i < DEPTH; i++) model[i].init = 1'b1;
        if (op == 2) for (int i = 0; i < DEPTH; i++) model[i].init = 1'b0;
        if (op >= 3 && op <= 5) begin
            if (len < 1 || len > 32) err = 1'b1;
            else for (int i = 0; i < DEPTH; i++) begin
                if (prefix_eq(model[i].color, col, len)) begin
                    model[i].init = (op != 5);
                    if (op == 4) begin
                        if (!model[i].imm_a) model[i].rdy_a = 1'b0;
                        if (!model[i].imm_b) model[i].rdy_b = 1'b0;
                    end
                end
            end
        end
    endtask

    task automatic check_all(input string req);
        logic [DEPTH-1:0] er;
        for (int i = 0; i < DEPTH; i++) er[i] = model[i].init;
        check(ready_vec == er, req, "ready_vec", FRAME_W'(ready_vec), FRAME_W'(er));
        for (int i = 0; i < DEPTH; i++) begin
            rd_addr = AW'(i);
            #1;
            check(rd_frame == model[i], req, $sformatf("frame %0d", i), rd_frame, model[i]);
        end
    endtask

    task automatic send(input int op, input logic [31:0] col, input int len,
                        input bit in_load, input string req);
        bit err;
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_color = col; cmd_len = 7'(len);
        load_mode = in_load;
        tick();
        cmd_valid = 1'b0; load_mode = 1'b0;
        err = 1'b0;
        if (!in_load) model_cmd(op, col, len, err);
        check(cmd_err == err, req, "cmd_err after edge", FRAME_W'(cmd_err), FRAME_W'(err));
        check_all(req);
        tick();
        check(cmd_err == 1'b0, req, "cmd_err second edge", FRAME_W'(cmd_err), '0);
    endtask

    task automatic t_reset();
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        rst = 1'b1; tick(); tick(); rst = 1'b0;
        check(cmd_err == 1'b0, "R1", "cmd_err", FRAME_W'(cmd_err), '0);
        check_all("R1");
    endtask

    task automatic t_load();
        logic [31:0] cols [DEPTH];
        cols = '{32'd4, 32'd6, 32'd7, 32'd5, 32'h8000_0004, 32'h8000_0006,
                 32'h0000_0100, 32'hFFFF_FFFF};
        load_mode = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            model[i] = mk(cols[i], (i == 3 || i == 6), i[0], i[1], i);
            ld_we = 1'b1; ld_addr = AW'(i); ld_frame = model[i];
            tick();
        end
        ld_we = 1'b0; load_mode = 1'b0;
        check_all("R2");
    endtask

    task automatic t_load_outside();
        ld_we = 1'b1; ld_addr = 3'd2; ld_frame = '1; load_mode = 1'b0;
        tick();
        ld_we = 1'b0;
        check_all("R3");
    endtask

    task automatic t_cmd_in_load();
        send(1, 32'd0, 0, 1'b1, "R4");
        send(2, 32'd0, 0, 1'b1, "R4");
    endtask

    task automatic t_whole();
        send(1, 32'd0, 0, 1'b0, "R5");
        check(ready_vec == '1, "R5", "all set", FRAME_W'(ready_vec), FRAME_W'(8'hFF));
        send(2, 32'd0, 0, 1'b0, "R6");
        check(ready_vec == '0, "R6", "all clear", FRAME_W'(ready_vec), '0);
    endtask

    task automatic t_subgraph();
        send(3, 32'd4, 30, 1'b0, "R7");
        check(ready_vec == 8'h0F, "R7", "len30 group", FRAME_W'(ready_vec), FRAME_W'(8'h0F));
        send(5, 32'd6, 31, 1'b0, "R8");
        check(ready_vec == 8'h09, "R8", "len31 kill", FRAME_W'(ready_vec), FRAME_W'(8'h09));
    endtask

    task automatic t_len_edges();
        send(3, 32'h8000_0000, 1, 1'b0, "R11");
        check(ready_vec == 8'hB9, "R11", "len1", FRAME_W'(ready_vec), FRAME_W'(8'hB9));
        send(2, 32'd0, 0, 1'b0, "R11");
        send(3, 32'd6, 32, 1'b0, "R11");
        check(ready_vec == 8'h02, "R11", "len32", FRAME_W'(ready_vec), FRAME_W'(8'h02));
    endtask

    task automatic t_ops_init();
        send(2, 32'd0, 0, 1'b0, "R9");
        send(4, 32'd4, 30, 1'b0, "R9");
        rd_addr = 3'd1; #1;
        check(rd_frame[134] == 1'b1 && rd_frame[132] == 1'b0, "R9", "frame1 rdy bits",
              FRAME_W'(rd_frame[135:128]), FRAME_W'(8'b1110_1010));
        rd_addr = 3'd2; #1;
        check(rd_frame[134] == 1'b0 && rd_frame[132] == 1'b1, "R9", "frame2 rdy bits",
              FRAME_W'(rd_frame[135:128]), FRAME_W'(8'b1011_0100));
    endtask

    task automatic t_bad_len();
        send(3, 32'h8000_0000, 0, 1'b0, "R10");
        send(5, 32'd4, 33, 1'b0, "R10");
        send(4, 32'd4, 127, 1'b0, "R10");
    endtask

    task automatic t_reserved();
        send(0, 32'd4, 30, 1'b0, "R12");
        send(6, 32'h8000_0000, 1, 1'b0, "R12");
        send(7, 32'd4, 0, 1'b0, "R12");
    endtask

    initial begin
        t_reset();
        t_load();
        t_load_outside();
        t_cmd_in_load();
        t_whole();
        t_subgraph();
        t_len_edges();
        t_ops_init();
        t_bad_len();
        t_reserved();
        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        #2000000;
        runs++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule